// File: doc/BRIEF.md
# Segmented Mismatch-Shaping DAC Encoder

This block turns an 8-bit unsigned code into ten 1-bit element drives. Off chip, a weighted resistor network sums the drives into an analog level. The elements come in five pairs. Both members of a pair carry the same weight, 2^s for pair s (s = 0..4). The code is first scaled to half-unit resolution on a 55-level grid (levels 0..54). A half-unit rounding cell then picks the integer level, and a greedy decomposition splits that level into per-pair counts of 0, 1 or 2.

Whenever a pair carries exactly one unit, a 1-bit steering state decides which member carries it. In the shaping modes that state flips after each use. Both members therefore carry the odd unit equally often, and their mismatch becomes first-order highpass-shaped error. The rounding cell works the same way on the half unit. This shapes the quantization error with no feedback loop at all.

Two control inputs form a 2-bit mode. The modes are static, toggle-shaped, random element selection from a free-running 16-bit LFSR, and toggle-shaped with a one-LSB dither taken from the same LFSR. The code and the mode bits are synchronized by two flops, and the element drives are registered.

Top module: `smdac_encoder`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all element drives, all steering states and the rounding state to 0, clears the synchronizer flops and loads the LFSR with 16'hACE1.
- R2: Inputs present at rising edge n show on `elemOut` after rising edge n+2. There are two synchronizer stages and one output register, and the mode bits travel with the code.
- R3: With c the code (plus dither in mode 3), the half-unit value is h = floor((c*108 + 128)/256). The level is floor(h/2) plus a rounding bit, and the rounding bit can be 1 only when h is odd.
- R4: Element drives 2s and 2s+1 both weigh 2^s. The pair counts are found from pair 4 down to pair 0: the count is 2 if the remainder is at least 2*2^s, 1 if it is at least 2^s, and 0 otherwise. The weighted sum of `elemOut` equals the level.
- R5: Mode 0 ({ditherEn,shapeEn}=00) uses a rounding bit of 0, and a lone unit of pair s always goes to drive 2s.
- R6: Mode 1 (01) makes the rounding bit equal to the rounding state when h is odd, and then flips that state. A lone unit of pair s goes to drive 2s+pairState[s], and that state then flips.
- R7: Mode 2 (10) takes the rounding bit from LFSR bit 1 (when h is odd) and the lone-unit choice of pair s from LFSR bit 2+s. All steering and rounding states hold.
- R8: Mode 3 (11) behaves as mode 1 with c = code + LFSR bit 0, a 9-bit sum in which 256 is allowed.
- R9: On every non-reset edge, in every mode, the LFSR shifts left with bit 0 taking bit15^bit14^bit12^bit3. An output uses the LFSR value from before the shift at that same edge. The LFSR is never zero.
- R10: The weighted output never exceeds 54. Code 0 gives 0, and code 255 gives 54 in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Encoder clock |
| rst | input | 1 | Synchronous reset, active high |
| codeIn | input | 8 | Unsigned input code |
| shapeEn | input | 1 | Mode bit 0 |
| ditherEn | input | 1 | Mode bit 1 |
| elemOut | output | 10 | Element drives; bits 2s and 2s+1 have weight 2^s |

## Verification
A wrong steering state does not change the weighted sum. It shows only as the lone unit of a pair sitting on the wrong member, and it is visible at the ports on the very next cycle in which that pair has an odd count. A wrong rounding state or LFSR value changes the level itself, either on the next odd-h cycle or on the first random or dithered cycle. The bench therefore carries an exact model of every state and compares the full drive vector on every cycle, not only the sum.

// File: rtl/smdac_pkg.sv
`timescale 1ns/1ps
package smdac_pkg;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_SHAPE  = 2'd1,
    MODE_RANDOM = 2'd2,
    MODE_DITHER = 2'd3
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic holdFixed;
    logic useToggle;
    logic useRandom;
    logic addDither;
  } steer_t;

endpackage

// File: rtl/smdac_sync.sv
`timescale 1ns/1ps
module smdac_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stageQ[0] <= '0;
        else     stageQ[0] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stageQ[i] <= '0;
        else     stageQ[i] <= stageQ[i-1];
      end
    end
  end

  assign dOut = stageQ[STAGES-1];

endmodule

// File: rtl/smdac_ctrl.sv
`timescale 1ns/1ps
module smdac_ctrl
  import smdac_pkg::*;
#(
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 'hD008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        modeSel,
  output steer_t            steer,
  output logic [LFSR_W-1:0] rndBits
);

  logic [LFSR_W-1:0] lfsrQ;
  logic              fbBit;
  mode_e             modeNow;

  assign fbBit = ^(lfsrQ & LFSR_TAPS);

  always_ff @(posedge clk) begin
    if (rst) lfsrQ <= LFSR_SEED;
    else     lfsrQ <= {lfsrQ[LFSR_W-2:0], fbBit};
  end

  assign rndBits = lfsrQ;
  assign modeNow = mode_e'(modeSel);

  always_comb begin
    steer = '0;
    unique case (modeNow)
      MODE_STATIC: steer.holdFixed = 1'b1;
      MODE_SHAPE:  steer.useToggle = 1'b1;
      MODE_RANDOM: steer.useRandom = 1'b1;
      MODE_DITHER: begin
        steer.useToggle = 1'b1;
        steer.addDither = 1'b1;
      end
      default:     steer.holdFixed = 1'b1;
    endcase
  end

  // R9
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst) lfsrQ != '0)
    else $error("lfsr reached the all-zero state");

endmodule

// File: rtl/smdac_datapath.sv
`timescale 1ns/1ps
module smdac_datapath
  import smdac_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LEVELS = 55,
  parameter int NSEG   = 5,
  parameter int LFSR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] codeQ,
  input  steer_t            steer,
  input  logic [LFSR_W-1:0] rndBits,
  output logic [2*NSEG-1:0] elemOut
);

  localparam int SPAN   = 2 * (LEVELS - 1);
  localparam int HALF_W = $clog2(SPAN + 1);
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int REM_W  = LVL_W + 2;
  localparam int PROD_W = CODE_W + 1 + HALF_W;
  localparam int ELEM_N = 2 * NSEG;
  localparam int SUM_W  = NSEG + 2;

  logic [CODE_W:0]     dithCode;
  logic [PROD_W-1:0]   scaled;
  logic [HALF_W-1:0]   halfVal;
  logic                roundPick;
  logic                roundBit;
  logic [LVL_W-1:0]    level;
  logic [1:0]          digit [NSEG];
  logic [REM_W-1:0]    remLeft;
  logic                halfState;
  logic [NSEG-1:0]     pairState;
  logic [NSEG-1:0]     pairSel;
  logic [ELEM_N-1:0]   elemNext;

  // scale to the half-unit grid, with optional one-LSB dither
  assign dithCode = {1'b0, codeQ} + {{CODE_W{1'b0}}, steer.addDither & rndBits[0]};
  assign scaled   = PROD_W'(dithCode) * PROD_W'(SPAN) + PROD_W'(2 ** (CODE_W - 1));
  assign halfVal  = scaled[CODE_W +: HALF_W];

  // half-unit rounding cell
  always_comb begin
    if (steer.useToggle)      roundPick = halfState;
    else if (steer.useRandom) roundPick = rndBits[1];
    else                      roundPick = 1'b0;
  end
  assign roundBit = halfVal[0] & roundPick;
  assign level    = LVL_W'(halfVal >> 1) + LVL_W'(roundBit);

  // greedy split of the level into per-pair counts, top pair first
  always_comb begin : splitDigits
    logic [REM_W-1:0] rem;
    rem = REM_W'(level);
    for (int s = NSEG - 1; s >= 0; s--) begin
      if (rem >= (REM_W'(2) << s)) begin
        digit[s] = 2'd2;
        rem      = rem - (REM_W'(2) << s);
      end else if (rem >= (REM_W'(1) << s)) begin
        digit[s] = 2'd1;
        rem      = rem - (REM_W'(1) << s);
      end else begin
        digit[s] = 2'd0;
      end
    end
    remLeft = rem;
  end

  // per-pair steering of the lone unit
  for (genvar s = 0; s < NSEG; s++) begin : g_pair
    assign pairSel[s] = steer.useToggle ? pairState[s]
                      : (steer.useRandom ? rndBits[2+s] : 1'b0);
    assign elemNext[2*s]   = (digit[s] == 2'd2) | ((digit[s] == 2'd1) & ~pairSel[s]);
    assign elemNext[2*s+1] = (digit[s] == 2'd2) | ((digit[s] == 2'd1) &  pairSel[s]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pairState <= '0;
    end else begin
      for (int s = 0; s < NSEG; s++) begin
        if (steer.useToggle && digit[s] == 2'd1) pairState[s] <= ~pairState[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elemOut   <= '0;
      halfState <= 1'b0;
    end else begin
      elemOut <= elemNext;
      if (steer.useToggle && halfVal[0]) halfState <= ~halfState;
    end
  end

  // ---------------- checks ----------------
  logic [SUM_W-1:0] outWeight;
  logic [NSEG-1:0]  loneHigh;

  always_comb begin
    outWeight = '0;
    for (int s = 0; s < NSEG; s++) begin
      outWeight = outWeight + ((SUM_W'(elemOut[2*s]) + SUM_W'(elemOut[2*s+1])) << s);
      loneHigh[s] = elemOut[2*s+1] & ~elemOut[2*s];
    end
  end

  // R4
  decomp_exact_chk: assert property (@(posedge clk) disable iff (rst) remLeft == '0)
    else $error("level not fully split across pairs");

  // R10
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    outWeight <= SUM_W'(LEVELS - 1))
    else $error("weighted output above top level");

  // R5
  static_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    steer.holdFixed |=> loneHigh == '0)
    else $error("static mode placed lone unit on odd element");

  // R7
  random_hold_chk: assert property (@(posedge clk) disable iff (rst)
    steer.useRandom |=> ($stable(pairState) && $stable(halfState)))
    else $error("steering state moved in random mode");

endmodule

// File: rtl/smdac_encoder.sv
`timescale 1ns/1ps
module smdac_encoder
  import smdac_pkg::*;
#(
  parameter int                CODE_W      = 8,
  parameter int                LEVELS      = 55,
  parameter int                NSEG        = 5,
  parameter int                SYNC_STAGES = 2,
  parameter int                LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED   = 'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS   = 'hD008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              shapeEn,
  input  logic              ditherEn,
  output logic [2*NSEG-1:0] elemOut
);

  localparam int SYNC_W = CODE_W + 2;

  logic [SYNC_W-1:0] rawIn;
  logic [SYNC_W-1:0] syncIn;
  steer_t            steer;
  logic [LFSR_W-1:0] rndBits;

  assign rawIn = {ditherEn, shapeEn, codeIn};

  smdac_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .dIn  (rawIn),
    .dOut (syncIn)
  );

  smdac_ctrl #(.LFSR_W(LFSR_W), .LFSR_SEED(LFSR_SEED), .LFSR_TAPS(LFSR_TAPS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .modeSel (syncIn[SYNC_W-1:CODE_W]),
    .steer   (steer),
    .rndBits (rndBits)
  );

  smdac_datapath #(.CODE_W(CODE_W), .LEVELS(LEVELS), .NSEG(NSEG), .LFSR_W(LFSR_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .codeQ   (syncIn[CODE_W-1:0]),
    .steer   (steer),
    .rndBits (rndBits),
    .elemOut (elemOut)
  );

endmodule

// File: tb/test_smdac_encoder.sv
`timescale 1ns/1ps
module test_smdac_encoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] codeIn = 8'd0;
  logic       shapeEn = 1'b0;
  logic       ditherEn = 1'b0;
  logic [9:0] elemOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit liveCheck = 1'b0;

  always #4 clk = ~clk;

  smdac_encoder i_smdac_encoder (
    .clk(clk), .rst(rst), .codeIn(codeIn),
    .shapeEn(shapeEn), .ditherEn(ditherEn), .elemOut(elemOut)
  );

  // ---- reference model built from the requirements ----
  logic [9:0]  mS1, mS2, expOut;
  logic [15:0] mLf;
  logic        mHalf;
  logic [4:0]  mPair;
  int          expLvl, expMode;

  function automatic int halfOf(int c);
    return (c * 108 + 128) >> 8;
  endfunction

  function automatic int weightOf(logic [9:0] v);
    int w = 0;
    for (int s = 0; s < 5; s++) w += (int'(v[2*s]) + int'(v[2*s+1])) << s;
    return w;
  endfunction

  always @(posedge clk) begin : refModel
    int c, h, r, lvl, rem, md, m, sel;
    logic [9:0] e;
    if (rst) begin
      mS1 = '0; mS2 = '0; expOut = '0; mLf = 16'hACE1;
      mHalf = 1'b0; mPair = '0; expLvl = 0; expMode = 0;
    end else begin
      md = int'(mS2[9:8]);
      c  = int'(mS2[7:0]) + ((md == 3) ? int'(mLf[0]) : 0);
      h  = halfOf(c);
      r  = 0;
      if (h % 2 == 1) begin
        if (md == 2)                 r = int'(mLf[1]);
        else if (md == 1 || md == 3) begin r = int'(mHalf); mHalf = ~mHalf; end
      end
      lvl = h / 2 + r;
      rem = lvl;
      e = '0;
      for (int s = 4; s >= 0; s--) begin
        m = (rem >= (2 << s)) ? 2 : ((rem >= (1 << s)) ? 1 : 0);
        rem -= m << s;
        if (m == 2) begin e[2*s] = 1'b1; e[2*s+1] = 1'b1; end
        else if (m == 1) begin
          if (md == 0)      sel = 0;
          else if (md == 2) sel = int'(mLf[2+s]);
          else begin sel = int'(mPair[s]); mPair[s] = ~mPair[s]; end
          e[2*s+sel] = 1'b1;
        end
      end
      expOut = e; expLvl = lvl; expMode = md;
      mLf = {mLf[14:0], mLf[15] ^ mLf[14] ^ mLf[12] ^ mLf[3]};
      mS2 = mS1;
      mS1 = {ditherEn, shapeEn, codeIn};
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every cycle: full vector and weighted level against the model
  always @(negedge clk) begin
    if (liveCheck && !finished) begin
      case (expMode)
        0: check(elemOut === expOut, "R5 static vector", int'(elemOut), int'(expOut));
        1: check(elemOut === expOut, "R6 shaped vector", int'(elemOut), int'(expOut));
        2: check(elemOut === expOut, "R7/R9 random vector", int'(elemOut), int'(expOut));
        default: check(elemOut === expOut, "R8/R9 dithered vector", int'(elemOut), int'(expOut));
      endcase
      check(weightOf(elemOut) == expLvl, "R3 R4 weighted level", weightOf(elemOut), expLvl);
    end
  end

  task automatic drive(int code, int mode);
    codeIn   = 8'(code);
    shapeEn  = mode[0];
    ditherEn = mode[1];
  endtask

  initial begin : stimulus
    int ones, e0, e1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(elemOut == 10'd0, "R1 outputs in reset", int'(elemOut), 0);
    rst = 1'b0;
    liveCheck = 1'b1;

    // R2 latency, with R4 decomposition of level 54 in static mode
    drive(255, 0);
    @(negedge clk); check(elemOut == 10'd0, "R2 latency edge1", int'(elemOut), 0);
    @(negedge clk); check(elemOut == 10'd0, "R2 latency edge2", int'(elemOut), 0);
    @(negedge clk); check(elemOut == 10'h3D4, "R2 R4 code255 static", int'(elemOut), 'h3D4);

    // R10 extremes
    drive(0, 1);
    repeat (3) @(negedge clk);
    check(weightOf(elemOut) == 0, "R10 code0", weightOf(elemOut), 0);
    drive(255, 3);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      check(weightOf(elemOut) == 54, "R10 R8 code255 dithered", weightOf(elemOut), 54);
      @(negedge clk);
    end

    // R6 half-unit shaping: code 3 gives h=1, level alternates 0/1
    drive(3, 1);
    repeat (3) @(negedge clk);
    ones = 0;
    for (int k = 0; k < 8; k++) begin ones += weightOf(elemOut); @(negedge clk); end
    check(ones == 4, "R6 rounding alternates", ones, 4);

    // R6 element shaping: code 4 gives level 1, lone unit alternates in pair 0
    drive(4, 1);
    repeat (3) @(negedge clk);
    e0 = 0; e1 = 0;
    for (int k = 0; k < 8; k++) begin
      e0 += int'(elemOut[0]); e1 += int'(elemOut[1]); @(negedge clk);
    end
    check(e0 == 4 && e1 == 4, "R6 pair0 alternates", e0 * 16 + e1, 'h44);

    // R5 static: lone unit fixed on even member
    drive(4, 0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(elemOut == 10'b01, "R5 fixed element", int'(elemOut), 1);
      @(negedge clk);
    end

    // R7 random selection on level 1
    drive(4, 2);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check((elemOut[0] ^ elemOut[1]) && elemOut[9:2] == 0, "R7 one lone unit",
            int'(elemOut), 1);
      @(negedge clk);
    end

    // constrained random: runs of held mode, random codes
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 15) == 0) begin
        shapeEn  = 1'($urandom_range(0, 1));
        ditherEn = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 3) != 0) begin
        case ($urandom_range(0, 5))
          0: codeIn = 8'd0;
          1: codeIn = 8'd255;
          2: codeIn = 8'($urandom_range(0, 8));
          default: codeIn = 8'($urandom_range(0, 255));
        endcase
      end
      @(negedge clk);
    end

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule